// File: doc/BRIEF.md
# Flash ECC Mode Controller

This block sits between a flash array controller and its error-correction codec. On every write it decides whether the word goes out protected by a full ECC code (quad write) or by simple parity (single write). It produces the small control tag that is stored next to the data so that a later read knows which protection was used. On every read it looks at the stored tag, picks the check to run, enables correction when the check is ECC, and turns the codec or parity-checker error flags into a sticky double-error status bit and, in some modes, a one-cycle bus-error pulse.

Four modes are set by a 2-bit mode input. Bypass mode runs no check at all. The two dynamic modes let each word choose its own protection through the tag, and they differ only in whether an uncorrectable error raises a bus error or is just logged. ECC-only mode forces ECC on every read and refuses single writes. The stored tag is read through a majority vote, so one flipped tag bit cannot change the check type. A fault input can flip tag bits on the read path so that this vote can be tested.

Top module: `flash_ecc_mode_ctrl`

## Requirements
- R1: With `wr_req_i` high and the write allowed, `wr_tag_o` is all zeros for a quad write (`wr_single_i`=0) and all ones for a single write (`wr_single_i`=1), in the same cycle. Mode codes are 2'b00 ECC-only, 2'b01 dynamic, 2'b10 dynamic-quiet and 2'b11 bypass.
- R2: In ECC-only mode a single write is refused. `wr_go_o` stays low in that cycle and `wr_illegal_o` is high for exactly the following cycle. Every other write request drives `wr_go_o` high in the same cycle.
- R3: In the two dynamic modes a read selects the parity check (`chk_par_o`) when at least two of the three effective tag bits are 1. Otherwise it selects the ECC check (`chk_ecc_o`). The two selects are never high together.
- R4: In bypass mode a read selects no check, and error flags change neither `ded_sts_o` nor `bus_err_o`, whatever the tag.
- R5: In ECC-only mode every read selects the ECC check, for any tag value.
- R6: In dynamic-quiet mode an uncorrectable error on a read sets `ded_sts_o` on the next cycle and never raises `bus_err_o`.
- R7: In dynamic and ECC-only modes an uncorrectable error on a read sets `ded_sts_o` and pulses `bus_err_o` for exactly the next cycle only.
- R8: `ded_sts_o` stays set until `ded_clr_i` is sampled high. A new error in the same cycle as the clear wins, and the bit stays set.
- R9: The effective tag is `rd_tag_i` XOR `tag_flip_i`, so flipping two bits of a stored 3'b000 turns the check into parity.
- R10: `corr_en_o` follows the ECC select. An uncorrectable error counts only from the selected check: `ecc_ded_i` when ECC is selected, `par_err_i` when parity is selected. The other flag is ignored.
- R11: After reset all registered outputs (`ded_sts_o`, `bus_err_o`, `wr_illegal_o`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Error-correction mode |
| wr_req_i | input | 1 | Write request |
| wr_single_i | input | 1 | 1 = single (parity) write, 0 = quad (ECC) write |
| wr_go_o | output | 1 | Write may proceed |
| wr_tag_o | output | TAG_W | Tag to store with the data |
| wr_illegal_o | output | 1 | One-cycle flag for a refused single write |
| rd_req_i | input | 1 | Read data and error flags valid |
| rd_tag_i | input | TAG_W | Tag read from the array |
| tag_flip_i | input | TAG_W | Fault injection mask XORed into the read tag |
| ecc_ded_i | input | 1 | Codec uncorrectable (double) error |
| par_err_i | input | 1 | Parity checker error |
| ded_clr_i | input | 1 | Clears the double-error status |
| chk_ecc_o | output | 1 | ECC check selected for this read |
| chk_par_o | output | 1 | Parity check selected for this read |
| corr_en_o | output | 1 | Codec correction enable |
| ded_sts_o | output | 1 | Sticky double-error status |
| bus_err_o | output | 1 | One-cycle bus-error pulse, the cycle after the read |

## Verification
The assertions assume that the codec and parity flags belong to the read presented in the same cycle, and that `mode_i` is always one of the four defined codes. They also assume that a write and a read are judged independently of each other. The stimulus drives the error flags only together with, or deliberately apart from, a known read tag and mode. It holds `tag_flip_i` at zero except in the fault-injection cases. It changes mode only between whole transactions.

// File: rtl/fecc_pkg.sv
package fecc_pkg;

   typedef enum logic [1:0] {
      FM_ECC_ONLY  = 2'b00,
      FM_DYN       = 2'b01,
      FM_DYN_QUIET = 2'b10,
      FM_BYPASS    = 2'b11
   } fecc_mode_e;

   typedef struct packed {
      logic chk_off;    // no check of any kind on reads
      logic tag_used;   // stored tag chooses the check
      logic single_ok;  // parity (single) writes permitted
      logic log_en;     // uncorrectable errors update status
      logic berr_en;    // uncorrectable errors raise a bus error
   } fecc_policy_t;

endpackage

// File: rtl/fecc_mode_dec.sv
module fecc_mode_dec
   import fecc_pkg::*;
(
   input  logic [1:0]   mode_i,
   output fecc_policy_t pol_o
);

   fecc_mode_e mode;

   always_comb begin
      mode  = fecc_mode_e'(mode_i);
      pol_o = '0;
      unique case (mode)
         FM_BYPASS: begin
            pol_o.chk_off   = 1'b1;
            pol_o.single_ok = 1'b1;
         end
         FM_DYN_QUIET: begin
            pol_o.tag_used  = 1'b1;
            pol_o.single_ok = 1'b1;
            pol_o.log_en    = 1'b1;
         end
         FM_DYN: begin
            pol_o.tag_used  = 1'b1;
            pol_o.single_ok = 1'b1;
            pol_o.log_en    = 1'b1;
            pol_o.berr_en   = 1'b1;
         end
         default: begin // FM_ECC_ONLY
            pol_o.log_en    = 1'b1;
            pol_o.berr_en   = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/fecc_tag_codec.sv
module fecc_tag_codec #(
   parameter int TAG_W = 3
) (
   input  logic             wr_single_i,
   input  logic             single_ok_i,
   output logic [TAG_W-1:0] wr_tag_o,
   input  logic [TAG_W-1:0] rd_tag_i,
   input  logic [TAG_W-1:0] flip_i,
   output logic             par_vote_o
);

   localparam int CNT_W = $clog2(TAG_W + 1);
   localparam int HALF  = TAG_W / 2;

   logic [TAG_W-1:0] eff_tag;

   assign wr_tag_o = (wr_single_i && single_ok_i) ? '1 : '0;
   assign eff_tag  = rd_tag_i ^ flip_i;

   generate
      if (TAG_W == 3) begin : g_vote3
         assign par_vote_o = (eff_tag[0] & eff_tag[1]) |
                             (eff_tag[0] & eff_tag[2]) |
                             (eff_tag[1] & eff_tag[2]);
      end else begin : g_vote_n
         logic [CNT_W-1:0] ones;
         always_comb begin
            ones = '0;
            for (int b = 0; b < TAG_W; b++) begin
               ones = ones + CNT_W'(eff_tag[b]);
            end
         end
         assign par_vote_o = (int'(ones) > HALF);
      end
   endgenerate

endmodule

// File: rtl/fecc_err_report.sv
module fecc_err_report (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic log_en_i,
   input  logic berr_en_i,
   input  logic clr_i,
   input  logic refuse_i,
   output logic ded_sts_o,
   output logic bus_err_o,
   output logic illegal_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ded_sts_o <= 1'b0;
         bus_err_o <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         if (evt_i && log_en_i) begin
            ded_sts_o <= 1'b1;
         end else if (clr_i) begin
            ded_sts_o <= 1'b0;
         end
         bus_err_o <= evt_i && berr_en_i;
         illegal_o <= refuse_i;
      end
   end

endmodule

// File: rtl/flash_ecc_mode_ctrl.sv
module flash_ecc_mode_ctrl
   import fecc_pkg::*;
#(
   parameter int TAG_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       mode_i,
   input  logic             wr_req_i,
   input  logic             wr_single_i,
   output logic             wr_go_o,
   output logic [TAG_W-1:0] wr_tag_o,
   output logic             wr_illegal_o,
   input  logic             rd_req_i,
   input  logic [TAG_W-1:0] rd_tag_i,
   input  logic [TAG_W-1:0] tag_flip_i,
   input  logic             ecc_ded_i,
   input  logic             par_err_i,
   input  logic             ded_clr_i,
   output logic             chk_ecc_o,
   output logic             chk_par_o,
   output logic             corr_en_o,
   output logic             ded_sts_o,
   output logic             bus_err_o
);

   generate
      if (TAG_W < 3 || (TAG_W % 2) == 0) begin : g_bad_tag_w
         $error("TAG_W must be odd and at least 3 for a majority vote");
      end
   endgenerate

   fecc_policy_t pol;
   logic         par_vote;
   logic         refuse;
   logic         ded_evt;

   fecc_mode_dec i_mode_dec (
      .mode_i (mode_i),
      .pol_o  (pol)
   );

   fecc_tag_codec #(.TAG_W(TAG_W)) i_tag_codec (
      .wr_single_i (wr_single_i),
      .single_ok_i (pol.single_ok),
      .wr_tag_o    (wr_tag_o),
      .rd_tag_i    (rd_tag_i),
      .flip_i      (tag_flip_i),
      .par_vote_o  (par_vote)
   );

   // write path
   assign refuse  = wr_req_i && wr_single_i && !pol.single_ok;
   assign wr_go_o = wr_req_i && !refuse;

   // read path: check selection
   assign chk_par_o = rd_req_i && !pol.chk_off && pol.tag_used && par_vote;
   assign chk_ecc_o = rd_req_i && !pol.chk_off && !(pol.tag_used && par_vote);
   assign corr_en_o = chk_ecc_o;

   assign ded_evt = (chk_ecc_o && ecc_ded_i) || (chk_par_o && par_err_i);

   fecc_err_report i_err_report (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (ded_evt),
      .log_en_i  (pol.log_en),
      .berr_en_i (pol.berr_en),
      .clr_i     (ded_clr_i),
      .refuse_i  (refuse),
      .ded_sts_o (ded_sts_o),
      .bus_err_o (bus_err_o),
      .illegal_o (wr_illegal_o)
   );

endmodule

// File: rtl/fecc_mode_ctrl_chk.sv
module fecc_mode_ctrl_chk #(
   parameter int TAG_W = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [1:0]       mode_i,
   input logic             wr_req_i,
   input logic             wr_single_i,
   input logic             wr_go_o,
   input logic [TAG_W-1:0] wr_tag_o,
   input logic             wr_illegal_o,
   input logic             rd_req_i,
   input logic             ded_clr_i,
   input logic             chk_ecc_o,
   input logic             chk_par_o,
   input logic             corr_en_o,
   input logic             ded_sts_o,
   input logic             bus_err_o
);

   assert_quad_tag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && !wr_single_i) |-> (wr_tag_o == '0));

   assert_single_refused_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && wr_single_i && mode_i == 2'b00) |-> !wr_go_o);

   assert_illegal_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && wr_single_i && mode_i == 2'b00) |=> wr_illegal_o);

   assert_select_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(chk_ecc_o && chk_par_o));

   assert_bypass_nocheck_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b11) |-> (!chk_ecc_o && !chk_par_o));

   assert_eonly_ecc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_i && mode_i == 2'b00) |-> chk_ecc_o);

   assert_quiet_no_berr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b10 || mode_i == 2'b11) |=> !bus_err_o);

   assert_berr_logged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_err_o |-> ded_sts_o);

   assert_sts_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ded_sts_o && !ded_clr_i) |=> ded_sts_o);

   assert_corr_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      corr_en_o |-> (rd_req_i && !chk_par_o));

endmodule

bind flash_ecc_mode_ctrl fecc_mode_ctrl_chk #(.TAG_W(TAG_W)) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .mode_i       (mode_i),
   .wr_req_i     (wr_req_i),
   .wr_single_i  (wr_single_i),
   .wr_go_o      (wr_go_o),
   .wr_tag_o     (wr_tag_o),
   .wr_illegal_o (wr_illegal_o),
   .rd_req_i     (rd_req_i),
   .ded_clr_i    (ded_clr_i),
   .chk_ecc_o    (chk_ecc_o),
   .chk_par_o    (chk_par_o),
   .corr_en_o    (corr_en_o),
   .ded_sts_o    (ded_sts_o),
   .bus_err_o    (bus_err_o)
);

// File: tb/test_flash_ecc_mode_ctrl.sv
module test_flash_ecc_mode_ctrl;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [1:0] mode_i = 2'b01;
   logic       wr_req_i = 1'b0;
   logic       wr_single_i = 1'b0;
   logic       wr_go_o;
   logic [2:0] wr_tag_o;
   logic       wr_illegal_o;
   logic       rd_req_i = 1'b0;
   logic [2:0] rd_tag_i = 3'b000;
   logic [2:0] tag_flip_i = 3'b000;
   logic       ecc_ded_i = 1'b0;
   logic       par_err_i = 1'b0;
   logic       ded_clr_i = 1'b0;
   logic       chk_ecc_o;
   logic       chk_par_o;
   logic       corr_en_o;
   logic       ded_sts_o;
   logic       bus_err_o;

   int n_vec = 0;
   int n_bad = 0;
   logic model_sts = 1'b0;

   typedef struct packed {
      logic ill;
      logic berr;
      logic sts;
   } exp_t;
   exp_t q[$];
   string qreq[$];

   always #10 clk_i = ~clk_i; // 50 MHz

   flash_ecc_mode_ctrl #(.TAG_W(3)) i_flash_ecc_mode_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mode_i       (mode_i),
      .wr_req_i     (wr_req_i),
      .wr_single_i  (wr_single_i),
      .wr_go_o      (wr_go_o),
      .wr_tag_o     (wr_tag_o),
      .wr_illegal_o (wr_illegal_o),
      .rd_req_i     (rd_req_i),
      .rd_tag_i     (rd_tag_i),
      .tag_flip_i   (tag_flip_i),
      .ecc_ded_i    (ecc_ded_i),
      .par_err_i    (par_err_i),
      .ded_clr_i    (ded_clr_i),
      .chk_ecc_o    (chk_ecc_o),
      .chk_par_o    (chk_par_o),
      .corr_en_o    (corr_en_o),
      .ded_sts_o    (ded_sts_o),
      .bus_err_o    (bus_err_o)
   );

   task automatic check(input string req, input string what,
                        input logic [3:0] act, input logic [3:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // driver: one call is one clock cycle
   task automatic apply(input string req, input logic [1:0] md,
                        input logic wr, input logic sgl,
                        input logic rd, input logic [2:0] tag, input logic [2:0] flip,
                        input logic ded, input logic par, input logic clr);
      logic [2:0] eff;
      int   ones;
      logic vote, eonly, byp, e_go, e_ecc, e_par, evt, e_ill, e_berr;
      logic [2:0] e_tag;
      exp_t item;
      @(negedge clk_i);
      mode_i = md; wr_req_i = wr; wr_single_i = sgl; rd_req_i = rd;
      rd_tag_i = tag; tag_flip_i = flip; ecc_ded_i = ded; par_err_i = par;
      ded_clr_i = clr;
      eff   = tag ^ flip;
      ones  = int'(eff[0]) + int'(eff[1]) + int'(eff[2]);
      vote  = (ones >= 2);
      eonly = (md == 2'b00);
      byp   = (md == 2'b11);
      e_ill = wr && sgl && eonly;
      e_go  = wr && !e_ill;
      e_tag = (sgl && !eonly) ? 3'b111 : 3'b000;
      e_ecc = rd && !byp && (eonly || !vote);
      e_par = rd && !byp && !eonly && vote;
      evt   = (e_ecc && ded) || (e_par && par);
      e_berr = evt && (md == 2'b01 || md == 2'b00);
      #2;
      if (wr) begin
         check(req, "wr_go", {3'b0, wr_go_o}, {3'b0, e_go});
         if (e_go) check(req, "wr_tag", {1'b0, wr_tag_o}, {1'b0, e_tag});
      end
      if (rd) begin
         check(req, "chk_ecc/chk_par/corr",
               {1'b0, chk_ecc_o, chk_par_o, corr_en_o},
               {1'b0, e_ecc, e_par, e_ecc});
      end
      if (evt) model_sts = 1'b1;
      else if (clr) model_sts = 1'b0;
      item.ill = e_ill; item.berr = e_berr; item.sts = model_sts;
      q.push_back(item);
      qreq.push_back(req);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) apply("idle", mode_i, 0, 0, 0, 3'b000, 3'b000, 0, 0, 0);
   endtask

   // monitor: registered outputs, compared the cycle after each driven vector
   initial begin
      forever begin
         @(posedge clk_i);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            string r;
            e = q.pop_front();
            r = qreq.pop_front();
            check(r, "ill/berr/sts", {1'b0, wr_illegal_o, bus_err_o, ded_sts_o},
                  {1'b0, e.ill, e.berr, e.sts});
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk_i);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_i);
      #2;
      // R11: reset state
      check("R11", "reset regs", {1'b0, wr_illegal_o, bus_err_o, ded_sts_o}, 4'h0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      // R1 / R2: writes in every mode
      for (int m = 0; m < 4; m++) begin
         apply("R1", 2'(m), 1, 0, 0, 3'b000, 3'b000, 0, 0, 0);
         apply("R2", 2'(m), 1, 1, 0, 3'b000, 3'b000, 0, 0, 0);
      end
      idle(1);

      // R3: every tag in dynamic mode, no errors
      for (int t = 0; t < 8; t++) apply("R3", 2'b01, 0, 0, 1, 3'(t), 3'b000, 0, 0, 0);
      // R5: every tag in ECC-only mode
      for (int t = 0; t < 8; t++) apply("R5", 2'b00, 0, 0, 1, 3'(t), 3'b000, 0, 0, 0);

      // R6: quiet dynamic mode logs without bus error
      apply("R6", 2'b10, 0, 0, 1, 3'b001, 3'b000, 1, 0, 0);
      apply("R6", 2'b10, 0, 0, 1, 3'b110, 3'b000, 0, 1, 0);
      // R8: status holds, then clears
      idle(3);
      apply("R8", 2'b10, 0, 0, 0, 3'b000, 3'b000, 0, 0, 1);
      idle(1);
      // R8: error and clear together keep status set
      apply("R8", 2'b01, 0, 0, 1, 3'b000, 3'b000, 1, 0, 1);
      apply("R8", 2'b01, 0, 0, 0, 3'b000, 3'b000, 0, 0, 1);

      // R7: dynamic mode bus error pulses, ECC and parity errors
      apply("R7", 2'b01, 0, 0, 1, 3'b010, 3'b000, 1, 0, 0);
      idle(2);
      apply("R7", 2'b01, 0, 0, 1, 3'b011, 3'b000, 0, 1, 1);
      apply("R7", 2'b01, 0, 0, 1, 3'b100, 3'b000, 1, 0, 0);
      apply("R7", 2'b00, 0, 0, 1, 3'b111, 3'b000, 1, 0, 1);
      idle(1);
      apply("R7", 2'b00, 0, 0, 0, 3'b000, 3'b000, 0, 0, 1);

      // R10: the flag of the unselected check is ignored
      apply("R10", 2'b01, 0, 0, 1, 3'b111, 3'b000, 1, 0, 0);
      apply("R10", 2'b01, 0, 0, 1, 3'b000, 3'b000, 0, 1, 0);
      apply("R10", 2'b00, 0, 0, 1, 3'b111, 3'b000, 0, 1, 0);
      idle(1);

      // R4: bypass ignores tags and flags
      for (int t = 0; t < 8; t += 3) apply("R4", 2'b11, 0, 0, 1, 3'(t), 3'b000, 1, 1, 0);
      idle(1);

      // R9: fault injection on the tag
      apply("R9", 2'b01, 0, 0, 1, 3'b000, 3'b011, 0, 0, 0);
      apply("R9", 2'b01, 0, 0, 1, 3'b001, 3'b001, 0, 0, 0);
      apply("R9", 2'b10, 0, 0, 1, 3'b111, 3'b101, 0, 0, 0);
      apply("R9", 2'b01, 0, 0, 1, 3'b000, 3'b110, 0, 1, 0);
      idle(3);

      summary();
      $finish;
   end

endmodule